// File: doc/BRIEF.md
# Quad-Lane Redundancy Switch Router

This block routes data between three four-lane ports, here called A, B and C, for link redundancy. In the merging direction, each lane of port C's output takes the matching lane of port A or of port B, chosen by one select bit per lane. In the splitting direction, port C's input lanes go to port A, to port B, or to both, depending on a fan-out mode (unicast or bicast). A lane word at an output that is not driven is marked idle and its data is held at zero.

Each port has its own loopback control. When loopback is on, the port's output carries the port's own input. This overrides the select and fan-out settings for that port only. Port C's pins are modelled as two lane groups, each with its own receive bus, transmit bus and output-enable. A single swap control decides which group transmits. Per-port equalization and pre-emphasis codes have no function in this model: they are stored and reported back.

All control inputs pass through one capture register, and they take effect together. Every lane has the same one-cycle data latency.

Top module: `quad_lane_redundancy_router`

## Requirements
- R1: With port C loopback off, lane i of port C's output carries lane i of port A when `lane_sel[i]` is 0, and lane i of port B when it is 1.
- R2: With loopback off on ports A and B and bicast off, port C's input lane i goes to port A when `lane_sel[i]` is 0 and to port B when it is 1. The lane at the other port is idle.
- R3: With bicast on and loopback off on ports A and B, every port C input lane drives both port A and port B, whatever its select bit.
- R4: When a port's loopback bit is set, every output lane of that port carries the same port's input lane and is not idle.
- R5: Loopback on one port leaves the routing of the other ports under R1 to R3.
- R6: An idle lane has its idle flag at 1 and its data at zero. A driven lane has its idle flag at 0.
- R7: Exactly one port C group has its output-enable set. With `swap_c_en` at 0, group 0 receives and group 1 transmits. With `swap_c_en` at 1, the roles are exchanged. The transmit bus of the group that is not enabled is zero.
- R8: `eq_rpt` and `pe_rpt` report the codes on `eq_set` and `pe_set` from the previous clock edge. Bit p of `eq_set`, and bits 2p+1:2p of `pe_set`, belong to port p, where A=0, B=1 and C=2. These codes have no effect on routing.
- R9: Control inputs are captured at a clock edge and govern the data transfer at the following edge, all together, with no mixed state.
- R10: Every output lane shows the value that its source input had one clock cycle earlier. The latency is the same on all lanes.
- R11: During reset and until the first transfer, port A lanes are driven with zero data, port B lanes are idle, group 1 transmits, and the reported codes are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| lane_sel | input | NUM_LANES | Per-lane source for port C output: 0 selects A, 1 selects B |
| bicast_en | input | 1 | Port C input fans out to both A and B |
| loop_a_en | input | 1 | Port A loopback |
| loop_b_en | input | 1 | Port B loopback |
| loop_c_en | input | 1 | Port C loopback |
| swap_c_en | input | 1 | Exchange the receive and transmit roles of port C groups |
| eq_set | input | 3 | Equalization code, one bit per port |
| pe_set | input | 6 | Pre-emphasis code, two bits per port |
| a_rx | input | NUM_LANES x LANE_W | Port A input lanes |
| b_rx | input | NUM_LANES x LANE_W | Port B input lanes |
| a_tx | output | NUM_LANES x LANE_W | Port A output lanes |
| a_tx_idle | output | NUM_LANES | Port A per-lane idle flags |
| b_tx | output | NUM_LANES x LANE_W | Port B output lanes |
| b_tx_idle | output | NUM_LANES | Port B per-lane idle flags |
| grp0_rx | input | NUM_LANES x LANE_W | Port C group 0 receive lanes |
| grp1_rx | input | NUM_LANES x LANE_W | Port C group 1 receive lanes |
| grp0_tx | output | NUM_LANES x LANE_W | Port C group 0 transmit lanes |
| grp1_tx | output | NUM_LANES x LANE_W | Port C group 1 transmit lanes |
| grp0_oe | output | 1 | Group 0 output-enable |
| grp1_oe | output | 1 | Group 1 output-enable |
| eq_rpt | output | 3 | Stored equalization codes |
| pe_rpt | output | 6 | Stored pre-emphasis codes |

## Verification
Two things can fall in the same cycle and interact: a change of configuration and a data transfer. This is most visible when a loopback bit or the port C swap flips at the same time as fresh data arrives. The stimulus changes controls on many consecutive cycles while the lane data keeps changing, including cycles where the swap and a loopback flip together. The reference model applies the controls captured one edge earlier to the data present at the transfer edge. Every output lane, idle flag and group enable is therefore compared against that one-edge-delayed configuration, and a mixed state fails the comparison.

// File: rtl/rr_pkg.sv
package rr_pkg;

    localparam int NUM_PORTS = 3;
    localparam int PORT_A    = 0;
    localparam int PORT_B    = 1;
    localparam int PORT_C    = 2;
    localparam int PE_W      = 2;

    typedef enum logic [1:0] {
        SRC_IDLE = 2'd0,
        SRC_A    = 2'd1,
        SRC_B    = 2'd2,
        SRC_C    = 2'd3
    } src_e;

    typedef struct packed {
        logic                                bicast;
        logic                                loop_a;
        logic                                loop_b;
        logic                                loop_c;
        logic                                swap_c;
        logic [NUM_PORTS-1:0]                eq;
        logic [NUM_PORTS-1:0][PE_W-1:0]      pe;
    } rr_cfg_t;

    // Source of a port A output lane
    function automatic src_e route_to_a(input rr_cfg_t c, input logic sel);
        if (c.loop_a)                 return SRC_A;
        else if (c.bicast || !sel)    return SRC_C;
        else                          return SRC_IDLE;
    endfunction

    // Source of a port B output lane
    function automatic src_e route_to_b(input rr_cfg_t c, input logic sel);
        if (c.loop_b)                 return SRC_B;
        else if (c.bicast || sel)     return SRC_C;
        else                          return SRC_IDLE;
    endfunction

    // Source of a port C output lane (never idle)
    function automatic src_e route_to_c(input rr_cfg_t c, input logic sel);
        if (c.loop_c)                 return SRC_C;
        else if (sel)                 return SRC_B;
        else                          return SRC_A;
    endfunction

endpackage

// File: rtl/rr_cfg_capture.sv
module rr_cfg_capture
    import rr_pkg::*;
#(
    parameter int NUM_LANES = 4
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [NUM_LANES-1:0] sel_in,
    input  rr_cfg_t              cfg_in,
    output logic [NUM_LANES-1:0] sel_q,
    output rr_cfg_t              cfg_q
);

    always_ff @(posedge clk) begin
        if (rst) begin
            sel_q <= '0;
            cfg_q <= '0;
        end else begin
            sel_q <= sel_in;
            cfg_q <= cfg_in;
        end
    end

    // R9: controls become visible together one edge after capture
    a_r9_sel_capture: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (sel_q == $past(sel_in)));
    a_r9_cfg_capture: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (cfg_q == $past(cfg_in)));

endmodule

// File: rtl/rr_lane.sv
module rr_lane
    import rr_pkg::*;
#(
    parameter int LANE_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  rr_cfg_t           cfg,
    input  logic              sel,
    input  logic [LANE_W-1:0] a_in,
    input  logic [LANE_W-1:0] b_in,
    input  logic [LANE_W-1:0] c_in,
    output logic [LANE_W-1:0] a_out,
    output logic              a_idle,
    output logic [LANE_W-1:0] b_out,
    output logic              b_idle,
    output logic [LANE_W-1:0] c_out
);

    src_e a_src, b_src, c_src;

    function automatic logic [LANE_W-1:0] pick(input src_e s,
                                               input logic [LANE_W-1:0] av,
                                               input logic [LANE_W-1:0] bv,
                                               input logic [LANE_W-1:0] cv);
        case (s)
            SRC_A:   return av;
            SRC_B:   return bv;
            SRC_C:   return cv;
            default: return '0;
        endcase
    endfunction

    always_comb begin
        a_src = route_to_a(cfg, sel);
        b_src = route_to_b(cfg, sel);
        c_src = route_to_c(cfg, sel);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            a_out  <= '0;
            a_idle <= 1'b0;
            b_out  <= '0;
            b_idle <= 1'b1;
            c_out  <= '0;
        end else begin
            a_out  <= pick(a_src, a_in, b_in, c_in);
            a_idle <= (a_src == SRC_IDLE);
            b_out  <= pick(b_src, a_in, b_in, c_in);
            b_idle <= (b_src == SRC_IDLE);
            c_out  <= pick(c_src, a_in, b_in, c_in);
        end
    end

    // R6: idle lanes carry zero data
    a_r6_idle_zero_a: assert property (@(posedge clk) disable iff (rst)
        a_idle |-> (a_out == '0));
    a_r6_idle_zero_b: assert property (@(posedge clk) disable iff (rst)
        b_idle |-> (b_out == '0));
    // R4: port A loopback returns port A input after one cycle
    a_r4_loop_a: assert property (@(posedge clk) disable iff (rst)
        cfg.loop_a |=> (!a_idle && a_out == $past(a_in)));
    a_r4_loop_b: assert property (@(posedge clk) disable iff (rst)
        cfg.loop_b |=> (!b_idle && b_out == $past(b_in)));
    // R3: bicast drives both sides
    a_r3_bicast_fanout: assert property (@(posedge clk) disable iff (rst)
        (cfg.bicast && !cfg.loop_a && !cfg.loop_b) |=>
            (!a_idle && !b_idle && a_out == b_out));
    // R2: unicast leaves exactly one side idle
    a_r2_unicast_one_idle: assert property (@(posedge clk) disable iff (rst)
        (!cfg.bicast && !cfg.loop_a && !cfg.loop_b) |=> (a_idle != b_idle));
    // R1: port C output follows the lane select
    a_r1_c_select: assert property (@(posedge clk) disable iff (rst)
        !cfg.loop_c |=> (c_out == ($past(sel) ? $past(b_in) : $past(a_in))));

endmodule

// File: rtl/rr_c_io.sv
module rr_c_io
    import rr_pkg::*;
#(
    parameter int NUM_LANES = 4,
    parameter int LANE_W    = 8
) (
    input  logic                              clk,
    input  logic                              rst,
    input  rr_cfg_t                           cfg,
    input  logic [NUM_LANES-1:0][LANE_W-1:0]  grp0_rx,
    input  logic [NUM_LANES-1:0][LANE_W-1:0]  grp1_rx,
    input  logic [NUM_LANES-1:0][LANE_W-1:0]  c_lane_out,
    output logic [NUM_LANES-1:0][LANE_W-1:0]  c_lane_in,
    output logic [NUM_LANES-1:0][LANE_W-1:0]  grp0_tx,
    output logic [NUM_LANES-1:0][LANE_W-1:0]  grp1_tx,
    output logic                              grp0_oe,
    output logic                              grp1_oe
);

    logic oe0_q, oe1_q;

    // Receive side follows the captured swap bit
    always_comb begin
        c_lane_in = cfg.swap_c ? grp1_rx : grp0_rx;
    end

    // Enables are registered with the data so both change on one edge
    always_ff @(posedge clk) begin
        if (rst) begin
            oe0_q <= 1'b0;
            oe1_q <= 1'b1;
        end else begin
            oe0_q <= cfg.swap_c;
            oe1_q <= !cfg.swap_c;
        end
    end

    generate
        for (genvar g = 0; g < NUM_LANES; g++) begin : g_tx
            always_comb begin
                grp0_tx[g] = oe0_q ? c_lane_out[g] : '0;
                grp1_tx[g] = oe1_q ? c_lane_out[g] : '0;
            end
        end
    endgenerate

    assign grp0_oe = oe0_q;
    assign grp1_oe = oe1_q;

    // R7: exactly one group transmits, a quiet group sends zero
    a_r7_single_oe: assert property (@(posedge clk) disable iff (rst)
        $countones({grp0_oe, grp1_oe}) == 1);
    a_r7_swap_follow: assert property (@(posedge clk) disable iff (rst)
        cfg.swap_c |=> grp0_oe);
    a_r7_quiet_grp0: assert property (@(posedge clk) disable iff (rst)
        !grp0_oe |-> (grp0_tx == '0));
    a_r7_quiet_grp1: assert property (@(posedge clk) disable iff (rst)
        !grp1_oe |-> (grp1_tx == '0));

endmodule

// File: rtl/quad_lane_redundancy_router.sv
module quad_lane_redundancy_router
    import rr_pkg::*;
#(
    parameter int NUM_LANES = 4,
    parameter int LANE_W    = 8
) (
    input  logic                              clk,
    input  logic                              rst,
    input  logic [NUM_LANES-1:0]              lane_sel,
    input  logic                              bicast_en,
    input  logic                              loop_a_en,
    input  logic                              loop_b_en,
    input  logic                              loop_c_en,
    input  logic                              swap_c_en,
    input  logic [2:0]                        eq_set,
    input  logic [5:0]                        pe_set,
    input  logic [NUM_LANES-1:0][LANE_W-1:0]  a_rx,
    input  logic [NUM_LANES-1:0][LANE_W-1:0]  b_rx,
    output logic [NUM_LANES-1:0][LANE_W-1:0]  a_tx,
    output logic [NUM_LANES-1:0]              a_tx_idle,
    output logic [NUM_LANES-1:0][LANE_W-1:0]  b_tx,
    output logic [NUM_LANES-1:0]              b_tx_idle,
    input  logic [NUM_LANES-1:0][LANE_W-1:0]  grp0_rx,
    input  logic [NUM_LANES-1:0][LANE_W-1:0]  grp1_rx,
    output logic [NUM_LANES-1:0][LANE_W-1:0]  grp0_tx,
    output logic [NUM_LANES-1:0][LANE_W-1:0]  grp1_tx,
    output logic                              grp0_oe,
    output logic                              grp1_oe,
    output logic [2:0]                        eq_rpt,
    output logic [5:0]                        pe_rpt
);

    rr_cfg_t                          cfg_in, cfg_q;
    logic [NUM_LANES-1:0]             sel_q;
    logic [NUM_LANES-1:0][LANE_W-1:0] c_in, c_out;

    always_comb begin
        cfg_in        = '0;
        cfg_in.bicast = bicast_en;
        cfg_in.loop_a = loop_a_en;
        cfg_in.loop_b = loop_b_en;
        cfg_in.loop_c = loop_c_en;
        cfg_in.swap_c = swap_c_en;
        cfg_in.eq     = eq_set;
        for (int p = 0; p < NUM_PORTS; p++) begin
            cfg_in.pe[p] = pe_set[p*PE_W +: PE_W];
        end
    end

    rr_cfg_capture #(.NUM_LANES(NUM_LANES)) u_cfg (
        .clk    (clk),
        .rst    (rst),
        .sel_in (lane_sel),
        .cfg_in (cfg_in),
        .sel_q  (sel_q),
        .cfg_q  (cfg_q)
    );

    rr_c_io #(.NUM_LANES(NUM_LANES), .LANE_W(LANE_W)) u_cio (
        .clk        (clk),
        .rst        (rst),
        .cfg        (cfg_q),
        .grp0_rx    (grp0_rx),
        .grp1_rx    (grp1_rx),
        .c_lane_out (c_out),
        .c_lane_in  (c_in),
        .grp0_tx    (grp0_tx),
        .grp1_tx    (grp1_tx),
        .grp0_oe    (grp0_oe),
        .grp1_oe    (grp1_oe)
    );

    generate
        for (genvar l = 0; l < NUM_LANES; l++) begin : g_lane
            rr_lane #(.LANE_W(LANE_W)) u_lane (
                .clk    (clk),
                .rst    (rst),
                .cfg    (cfg_q),
                .sel    (sel_q[l]),
                .a_in   (a_rx[l]),
                .b_in   (b_rx[l]),
                .c_in   (c_in[l]),
                .a_out  (a_tx[l]),
                .a_idle (a_tx_idle[l]),
                .b_out  (b_tx[l]),
                .b_idle (b_tx_idle[l]),
                .c_out  (c_out[l])
            );
        end
    endgenerate

    // R8: analog settings are only stored and reported
    assign eq_rpt = cfg_q.eq;
    assign pe_rpt = cfg_q.pe;

    a_r8_report_eq: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (eq_rpt == $past(eq_set)));
    a_r8_report_pe: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (pe_rpt == $past(pe_set)));

endmodule

// File: tb/tb_quad_lane_redundancy_router.sv
module tb_quad_lane_redundancy_router;

    localparam int NL = 4;
    localparam int W  = 8;

    logic clk = 1'b0;
    logic rst;
    logic [NL-1:0]        lane_sel;
    logic                 bicast_en, loop_a_en, loop_b_en, loop_c_en, swap_c_en;
    logic [2:0]           eq_set;
    logic [5:0]           pe_set;
    logic [NL-1:0][W-1:0] a_rx, b_rx, grp0_rx, grp1_rx;
    logic [NL-1:0][W-1:0] a_tx, b_tx, grp0_tx, grp1_tx;
    logic [NL-1:0]        a_tx_idle, b_tx_idle;
    logic                 grp0_oe, grp1_oe;
    logic [2:0]           eq_rpt;
    logic [5:0]           pe_rpt;

    int checks = 0;
    int failures = 0;
    bit done = 0;

    // Model of captured controls (applied at the next transfer)
    logic [NL-1:0] m_sel;
    logic m_bic, m_la, m_lb, m_lc, m_sw;

    always #2 clk = ~clk;

    quad_lane_redundancy_router #(.NUM_LANES(NL), .LANE_W(W)) dut (
        .clk(clk), .rst(rst), .lane_sel(lane_sel), .bicast_en(bicast_en),
        .loop_a_en(loop_a_en), .loop_b_en(loop_b_en), .loop_c_en(loop_c_en),
        .swap_c_en(swap_c_en), .eq_set(eq_set), .pe_set(pe_set),
        .a_rx(a_rx), .b_rx(b_rx), .a_tx(a_tx), .a_tx_idle(a_tx_idle),
        .b_tx(b_tx), .b_tx_idle(b_tx_idle), .grp0_rx(grp0_rx), .grp1_rx(grp1_rx),
        .grp0_tx(grp0_tx), .grp1_tx(grp1_tx), .grp0_oe(grp0_oe), .grp1_oe(grp1_oe),
        .eq_rpt(eq_rpt), .pe_rpt(pe_rpt)
    );

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic rand_data();
        for (int i = 0; i < NL; i++) begin
            a_rx[i]    = W'($urandom);
            b_rx[i]    = W'($urandom);
            grp0_rx[i] = W'($urandom);
            grp1_rx[i] = W'($urandom);
        end
    endtask

    task automatic set_cfg(input logic [NL-1:0] s, input logic bi, input logic la,
                           input logic lb, input logic lc, input logic sw);
        lane_sel = s; bicast_en = bi; loop_a_en = la;
        loop_b_en = lb; loop_c_en = lc; swap_c_en = sw;
    endtask

    // One transfer: predict, clock, compare, advance model, new data
    task automatic step();
        logic [NL-1:0][W-1:0] ea, eb, ec, e0, e1;
        logic [NL-1:0]        eai, ebi;
        logic [W-1:0]         cin;
        logic [2:0]           n_eq;
        logic [5:0]           n_pe;
        logic                 changed;
        string                ta, tb_, tc;
        for (int i = 0; i < NL; i++) begin
            cin = m_sw ? grp1_rx[i] : grp0_rx[i];
            if (m_la)                         begin ea[i] = a_rx[i]; eai[i] = 1'b0; end
            else if (m_bic || !m_sel[i])      begin ea[i] = cin;     eai[i] = 1'b0; end
            else                              begin ea[i] = '0;      eai[i] = 1'b1; end
            if (m_lb)                         begin eb[i] = b_rx[i]; ebi[i] = 1'b0; end
            else if (m_bic || m_sel[i])       begin eb[i] = cin;     ebi[i] = 1'b0; end
            else                              begin eb[i] = '0;      ebi[i] = 1'b1; end
            ec[i] = m_lc ? cin : (m_sel[i] ? b_rx[i] : a_rx[i]);
        end
        e0 = m_sw ? ec : '0;
        e1 = m_sw ? '0 : ec;
        n_eq = eq_set;
        n_pe = pe_set;
        changed = ({lane_sel, bicast_en, loop_a_en, loop_b_en, loop_c_en, swap_c_en}
                   != {m_sel, m_bic, m_la, m_lb, m_lc, m_sw});
        ta  = m_la ? "R4 portA" : ((m_lb || m_lc) ? "R5 portA" : (m_bic ? "R3 portA" : "R2 portA"));
        tb_ = m_lb ? "R4 portB" : ((m_la || m_lc) ? "R5 portB" : (m_bic ? "R3 portB" : "R2 portB"));
        tc  = m_lc ? "R4 portC" : ((m_la || m_lb) ? "R5 portC" : "R1 portC");
        @(posedge clk);
        @(negedge clk);
        for (int i = 0; i < NL; i++) begin
            chk(eai[i] ? "R6 portA idle lane" : ta, {55'd0, a_tx_idle[i], a_tx[i]}, {55'd0, eai[i], ea[i]});
            chk(ebi[i] ? "R6 portB idle lane" : tb_, {55'd0, b_tx_idle[i], b_tx[i]}, {55'd0, ebi[i], eb[i]});
        end
        chk(tc, 64'(m_sw ? grp0_tx : grp1_tx), 64'(ec));
        chk("R7 group enables", {62'd0, grp0_oe, grp1_oe}, {62'd0, m_sw, !m_sw});
        chk("R7 quiet group zero", 64'(m_sw ? grp1_tx : grp0_tx), 64'(m_sw ? e1 : e0));
        chk("R8 stored codes", {55'd0, eq_rpt, pe_rpt}, {55'd0, n_eq, n_pe});
        chk("R10 all lanes one-cycle latency", {a_tx, b_tx}, {ea, eb});
        if (changed)
            chk("R9 config change applies next edge", {a_tx_idle, b_tx_idle, a_tx, b_tx},
                {eai, ebi, ea, eb});
        m_sel = lane_sel; m_bic = bicast_en; m_la = loop_a_en;
        m_lb = loop_b_en; m_lc = loop_c_en; m_sw = swap_c_en;
        rand_data();
    endtask

    initial begin
        #(4 * 200000);
        if (!done) begin
            failures++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        rst = 1'b1;
        set_cfg('0, 0, 0, 0, 0, 0);
        eq_set = 3'b101;
        pe_set = 6'b110110;
        rand_data();
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R11: reset state
        chk("R11 reset portA", {a_tx_idle, a_tx}, '0);
        chk("R11 reset portB idle", {56'd0, b_tx_idle, b_tx}, {56'd0, {NL{1'b1}}, {(NL*W){1'b0}}});
        chk("R11 reset group enables", {62'd0, grp0_oe, grp1_oe}, 64'd1);
        chk("R11 reset codes", {55'd0, eq_rpt, pe_rpt}, '0);
        rst = 1'b0;
        m_sel = '0; m_bic = 0; m_la = 0; m_lb = 0; m_lc = 0; m_sw = 0;
        eq_set = '0; pe_set = '0;

        // Directed patterns
        set_cfg(4'b0101, 0, 0, 0, 0, 0); repeat (3) step();   // R2 unicast mixed
        set_cfg(4'b1010, 1, 0, 0, 0, 0); repeat (3) step();   // R3 bicast
        set_cfg(4'b0110, 0, 1, 0, 0, 0); repeat (3) step();   // R4/R5 loop A
        set_cfg(4'b1001, 0, 0, 1, 0, 0); repeat (3) step();   // loop B
        set_cfg(4'b0011, 1, 0, 0, 1, 0); repeat (3) step();   // loop C with bicast
        set_cfg(4'b1100, 0, 0, 0, 0, 1); repeat (3) step();   // R7 swap
        set_cfg(4'b1100, 0, 0, 0, 1, 1); repeat (3) step();   // swap + loop C
        set_cfg(4'b1111, 1, 1, 1, 1, 1); repeat (3) step();   // all loops
        // R8: codes change, routing unchanged
        set_cfg(4'b0101, 0, 0, 0, 0, 0);
        for (int k = 0; k < 8; k++) begin
            eq_set = 3'(k); pe_set = 6'(k * 9);
            step();
        end
        // R9: swap and loopback flip together on back-to-back cycles
        for (int k = 0; k < 6; k++) begin
            set_cfg(4'(k), k[0], 0, k[0], 0, k[0]);
            step();
        end
        // Random sequences with frequent changes
        for (int k = 0; k < 600; k++) begin
            if (($urandom % 3) == 0) begin
                set_cfg(NL'($urandom), 1'($urandom), 1'($urandom), 1'($urandom),
                        1'($urandom), 1'($urandom));
                eq_set = 3'($urandom); pe_set = 6'($urandom);
            end
            step();
        end
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule